// File: doc/BRIEF.md
# SMM Memory Access Controller

This block decides where each memory access goes when protected system-management memory is in play. It keeps three small configuration registers: a main SMRAM control register, an extended control register and a TSEG size register. For every access it takes the address and a flag that says whether the requester is in SMM. It then returns one of three routes: DRAM, PCI, or a blackhole that reads as all ones and drops writes.

Three protected areas are handled. The first is the legacy 128 KB window at 0xA0000. The second is a high alias of that same DRAM at 0xFEDA0000. The third is a TSEG area placed directly below the top-of-low-memory input. Software can open the legacy window to normal-mode code while it sets things up. It then sets a lock bit, which closes the window and freezes both control registers until the next reset. The extended size register lets software find out the configured TSEG size: writing the query value makes the register report that size in megabytes.

The route is combinational from the registers and the access inputs. Register writes take effect at the next clock edge.

Top module: `smm_access_ctrl`

## Requirements
- R1: Reset is active low and asynchronous. While it holds and after it releases, the readbacks are as follows. Select 0 (control register) reads 0x0002. Select 1 (extended control) reads 0x0000. Select 2 (size register) reads 0xFFFF when the extended size parameter is non-zero, and 0x0000 otherwise. Select 3 always reads 0.
- R2: While unlocked, a write to select 0 updates bit 6 (open), bit 4 (lock) and bit 3 (global enable). Bits 2:0 always read 3'b010 and all other bits read 0. A write to select 1 updates bit 7 (high-alias enable), bits 2:1 (TSEG size code) and bit 0 (TSEG enable); its other bits read 0. Each write is visible on the readback after the next rising clock edge.
- R3: When a write leaves the lock bit set, the open bit is cleared in that same update. From then until reset, writes to selects 0 and 1 change nothing.
- R4: A normal-mode access to 0xA0000–0xBFFFF routes to DRAM when open=1 and high-enable=0. Otherwise it routes to PCI.
- R5: A normal-mode access to 0xFEDA0000–0xFEDBFFFF routes to DRAM when open=1 and high-enable=1. Otherwise it takes the default route.
- R6: An SMM access routes to DRAM in the legacy window when global-enable=1 and high-enable=0. It routes to DRAM in the high alias when global-enable=1 and high-enable=1. In every other case an SMM access is routed like a normal-mode access.
- R7: TSEG is active only when TSEG enable and global enable are both 1. Size code 0 gives 1 MB, code 1 gives 2 MB, code 2 gives 8 MB, and code 3 gives the extended size parameter in MB (clamped to its maximum). TSEG covers [tolm − size, tolm).
- R8: Inside an active TSEG, a normal-mode access routes to blackhole (code 2) and an SMM access routes to DRAM.
- R9: A write to select 2 stores the data. The exception is the value 0xFFFF when the extended size is non-zero: the register then reads back the extended size.
- R10: Route codes are 0 for DRAM, 1 for PCI and 2 for blackhole. Code 3 never appears. Outside all special areas, an address below tolm routes to DRAM and anything else routes to PCI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 control, 1 extended control, 2 size) |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Readback of the selected register |
| tolm | input | AW | Top of low memory |
| acc_addr | input | AW | Access address |
| acc_smm | input | 1 | Access issued in SMM |
| route | output | 2 | Route decision |

## Verification
The assertions take for granted three things about the inputs. First, tolm is at least as large as the largest TSEG size, so the TSEG base never wraps. Second, tolm sits above the legacy window and below the high alias, so the areas never overlap. Third, reset is applied before any write. The stimulus keeps tolm fixed at 0x80000000 and probes addresses only at the edges of each area. It only writes register values that keep those assumptions, including writes that try to clear the lock or reopen the window after locking.

// File: rtl/smm_access_ctrl.sv
module smm_access_ctrl #(
  parameter int AW = 32,
  parameter int EXT_TSEG_MB = 16,
  parameter int EXT_TSEG_MB_MAX = 4095,
  parameter logic [31:0] LEG_BASE = 32'h000A_0000,
  parameter logic [31:0] HIGH_BASE = 32'hFEDA_0000,
  parameter logic [31:0] WIN_BYTES = 32'h0002_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [15:0]   cfg_wdata,
  output logic [15:0]   cfg_rdata,
  input  logic [AW-1:0] tolm,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_smm,
  output logic [1:0]    route
);
  localparam int EXT_MB = (EXT_TSEG_MB > EXT_TSEG_MB_MAX) ? EXT_TSEG_MB_MAX : EXT_TSEG_MB;
  localparam logic [15:0] QUERY = 16'hFFFF;
  localparam logic [15:0] SIZE_RST = (EXT_MB > 0) ? QUERY : 16'h0000;
  localparam int B_OPEN = 6, B_LOCK = 4, B_GEN = 3, B_HEN = 7, B_TEN = 0;
  localparam logic [7:0] CTL_RST = 8'h02, CTL_WM = 8'h58, EXT_WM = 8'h87;
  localparam logic [1:0] R_DRAM = 2'd0, R_PCI = 2'd1, R_BH = 2'd2;

  logic [7:0]  smram_q, ext_q, smram_nx;
  logic [15:0] size_q;
  logic        locked;
  logic [7:0]  ctl_wm, ext_wm;
  logic [12:0] tseg_mb;
  logic [AW-1:0] tseg_bytes, tseg_lo;
  logic        open_b, gen_b, hen_b, tseg_on, in_leg, in_hi, in_tseg;
  logic [1:0]  dflt;

  assign locked = smram_q[B_LOCK];
  assign ctl_wm = locked ? 8'h00 : CTL_WM;
  assign ext_wm = locked ? 8'h00 : EXT_WM;

  always_comb begin
    smram_nx = (smram_q & ~ctl_wm) | (cfg_wdata[7:0] & ctl_wm);
    if (smram_nx[B_LOCK]) smram_nx[B_OPEN] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smram_q <= CTL_RST;
      ext_q   <= 8'h00;
      size_q  <= SIZE_RST;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: smram_q <= smram_nx;
        2'd1: ext_q <= (ext_q & ~ext_wm) | (cfg_wdata[7:0] & ext_wm);
        2'd2: size_q <= (EXT_MB > 0 && cfg_wdata == QUERY) ? 16'(EXT_MB) : cfg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_sel)
      2'd0: cfg_rdata = {8'h00, smram_q};
      2'd1: cfg_rdata = {8'h00, ext_q};
      2'd2: cfg_rdata = size_q;
      default: cfg_rdata = 16'h0000;
    endcase
  end

  assign open_b = smram_q[B_OPEN];
  assign gen_b  = smram_q[B_GEN];
  assign hen_b  = ext_q[B_HEN];
  assign tseg_on = ext_q[B_TEN] && gen_b;

  always_comb begin
    case (ext_q[2:1])
      2'd0: tseg_mb = 13'd1;
      2'd1: tseg_mb = 13'd2;
      2'd2: tseg_mb = 13'd8;
      default: tseg_mb = 13'(EXT_MB);
    endcase
  end

  assign tseg_bytes = AW'(tseg_mb) << 20;
  assign tseg_lo = tolm - tseg_bytes;
  assign in_tseg = tseg_on && acc_addr >= tseg_lo && acc_addr < tolm;
  assign in_leg = acc_addr >= AW'(LEG_BASE) && acc_addr < AW'(LEG_BASE + WIN_BYTES);
  assign in_hi  = acc_addr >= AW'(HIGH_BASE) && acc_addr < AW'(HIGH_BASE + WIN_BYTES);
  assign dflt = (acc_addr < tolm) ? R_DRAM : R_PCI;

  always_comb begin
    if (in_tseg)
      route = acc_smm ? R_DRAM : R_BH;
    else if (in_leg)
      route = ((acc_smm && gen_b && !hen_b) || (open_b && !hen_b)) ? R_DRAM : R_PCI;
    else if (in_hi)
      route = ((acc_smm && gen_b && hen_b) || (open_b && hen_b)) ? R_DRAM : dflt;
    else
      route = dflt;
  end
endmodule

// File: rtl/smm_access_chk.sv
module smm_access_chk #(
  parameter int EXT_MB = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [1:0]  cfg_sel,
  input logic [15:0] cfg_wdata,
  input logic        acc_smm,
  input logic [1:0]  route,
  input logic [7:0]  smram_q,
  input logic [7:0]  ext_q,
  input logic [15:0] size_q
);
  a_r3_lock_closes_open: assert property (@(posedge clk) disable iff (!rst_n)
    smram_q[4] |-> !smram_q[6]);

  a_r3_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    smram_q[4] |=> (smram_q[4] && $stable(smram_q) && $stable(ext_q)));

  a_r8_blackhole_normal_only: assert property (@(posedge clk) disable iff (!rst_n)
    route == 2'd2 |-> !acc_smm);

  a_r9_query_answer: assert property (@(posedge clk) disable iff (!rst_n)
    (EXT_MB > 0 && cfg_we && cfg_sel == 2'd2 && cfg_wdata == 16'hFFFF) |=> size_q == 16'(EXT_MB));

  a_r10_route_code: assert property (@(posedge clk) disable iff (!rst_n)
    route != 2'd3);
endmodule

bind smm_access_ctrl smm_access_chk #(.EXT_MB(EXT_MB)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .acc_smm(acc_smm), .route(route), .smram_q(smram_q), .ext_q(ext_q), .size_q(size_q)
);

// File: tb/sim_smm_access_ctrl.sv
`timescale 1ns/1ps
module sim_smm_access_ctrl;
  localparam int EXT = 16;
  logic clk = 0, rst_n = 0, cfg_we = 0, acc_smm = 0;
  logic [1:0] cfg_sel = 0;
  logic [15:0] cfg_wdata = 0;
  logic [31:0] tolm = 32'h8000_0000, acc_addr = 0;
  wire [15:0] cfg_rdata;
  wire [1:0] route;
  int checks = 0, failures = 0, cycles = 0;
  string cur_req = "R1";
  logic [7:0] m_ctl, m_ext;
  logic [15:0] m_size;

  always #4 clk = ~clk;

  smm_access_ctrl #(.EXT_TSEG_MB(EXT)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tolm(tolm), .acc_addr(acc_addr), .acc_smm(acc_smm), .route(route)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl <= 8'h02; m_ext <= 8'h00; m_size <= 16'hFFFF;
    end else if (cfg_we) begin
      if (cfg_sel == 0 && !m_ctl[4]) begin
        logic [7:0] v;
        v = (cfg_wdata[7:0] & 8'h58) | 8'h02;
        if (v[4]) v[6] = 1'b0;
        m_ctl <= v;
      end
      if (cfg_sel == 1 && !m_ctl[4]) m_ext <= cfg_wdata[7:0] & 8'h87;
      if (cfg_sel == 2) m_size <= (cfg_wdata == 16'hFFFF) ? 16'(EXT) : cfg_wdata;
    end
  end

  function automatic logic [1:0] model_route();
    longint a = acc_addr, tl = tolm, mb;
    bit g = m_ctl[3], op = m_ctl[6], h = m_ext[7], s = acc_smm;
    case (m_ext[2:1]) 0: mb = 1; 1: mb = 2; 2: mb = 8; default: mb = EXT; endcase
    if (m_ext[0] && g && a >= tl - mb * 1048576 && a < tl) return s ? 2'd0 : 2'd2;
    if (a >= 'hA0000 && a < 'hC0000) return ((s && g && !h) || (op && !h)) ? 2'd0 : 2'd1;
    if (a >= 'hFEDA0000 && a < 'hFEDC0000 && ((s && g && h) || (op && h))) return 2'd0;
    return (a < tl) ? 2'd0 : 2'd1;
  endfunction

  task automatic compare();
    logic [15:0] er;
    logic [1:0] ert;
    case (cfg_sel) 0: er = {8'h0, m_ctl}; 1: er = {8'h0, m_ext}; 2: er = m_size; default: er = 0; endcase
    ert = model_route();
    checks += 2;
    if (cfg_rdata !== er) begin
      failures++;
      $display("FAIL %s readback sel=%0d actual=%h expected=%h", cur_req, cfg_sel, cfg_rdata, er);
    end
    if (route !== ert) begin
      failures++;
      $display("FAIL %s route addr=%h smm=%0b actual=%0d expected=%0d", cur_req, acc_addr, acc_smm, route, ert);
    end
  endtask

  task automatic cyc(input logic we, input logic [1:0] sel, input logic [15:0] wd,
                     input logic [31:0] addr, input logic smm);
    @(negedge clk);
    compare();
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd; acc_addr = addr; acc_smm = smm;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] wd);
    cyc(1, sel, wd, 32'h0, 0);
    cyc(0, sel, 16'h0, 32'h0, 0);
  endtask

  task automatic probe_windows();
    logic [31:0] pts [6] = '{32'h000A_0000, 32'h000B_FFFF, 32'h000C_0000,
                             32'hFEDA_0000, 32'hFEDB_FFFF, 32'hFEDC_0000};
    for (int i = 0; i < 6; i++)
      for (int s = 0; s < 2; s++) cyc(0, 0, 0, pts[i], s[0]);
  endtask

  task automatic probe_tseg(input int mb);
    logic [31:0] lo = tolm - mb * 32'h10_0000;
    logic [31:0] pts [4] = '{lo - 1, lo, tolm - 1, tolm};
    for (int i = 0; i < 4; i++)
      for (int s = 0; s < 2; s++) cyc(0, 1, 0, pts[i], s[0]);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    cyc(0, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0);
    @(negedge clk); rst_n = 1;
    for (int k = 0; k < 4; k++) cyc(0, k[1:0], 0, 0, 0);
    cyc(0, 3, 0, 0, 0);
    cur_req = "R10";
    cyc(0, 0, 0, 32'h7FFF_FFFF, 0); cyc(0, 0, 0, 32'h8000_0000, 1);
    cyc(0, 0, 0, 32'hFFFF_FFFF, 0); cyc(0, 0, 0, 32'h0, 0);
    cur_req = "R2";
    wr(0, 16'hFFEF); wr(1, 16'hFFFF); cyc(0, 1, 0, 0, 0);
    wr(0, 16'h0000); wr(1, 16'h0000);
    for (int c = 0; c < 8; c++) begin
      cur_req = c[0] ? "R5" : "R4";
      wr(0, {9'h0, c[0], 2'b0, c[1], 3'b0});
      wr(1, {8'h0, c[2], 7'h0});
      probe_windows();
      cur_req = "R6";
      probe_windows();
    end
    cur_req = "R7";
    wr(0, 16'h0000);
    for (int code = 0; code < 4; code++) begin
      wr(1, 16'(code * 2 + 1));
      probe_tseg(code == 3 ? EXT : (code == 2 ? 8 : code + 1));
    end
    cur_req = "R8";
    wr(0, 16'h0008);
    for (int code = 0; code < 4; code++) begin
      wr(1, 16'(code * 2 + 1));
      probe_tseg(code == 3 ? EXT : (code == 2 ? 8 : code + 1));
    end
    cur_req = "R9";
    wr(2, 16'hFFFF); cyc(0, 2, 0, 0, 0);
    wr(2, 16'h1234); wr(2, 16'hFFFE); wr(2, 16'hFFFF); wr(2, 16'h0000);
    cur_req = "R3";
    wr(0, 16'h0040); wr(1, 16'h0000); cyc(0, 0, 0, 32'hA0000, 0);
    wr(0, 16'h0058); cyc(0, 0, 0, 32'hA0000, 0);
    wr(0, 16'h0040); wr(0, 16'h0000); wr(1, 16'h0087);
    cyc(0, 1, 0, 32'hA0000, 0); cyc(0, 0, 0, 32'hA0000, 1);
    cur_req = "R1";
    @(negedge clk); rst_n = 0;
    cyc(0, 0, 0, 0, 0); cyc(0, 2, 0, 0, 0);
    @(negedge clk); rst_n = 1;
    cyc(0, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0); cyc(0, 2, 0, 0, 0);
    cur_req = "R4";
    wr(0, 16'h0040); cyc(0, 0, 0, 32'hA0000, 0); cyc(0, 0, 0, 32'hB0000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule